// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block takes an SDRAM device from power-up to normal operation by issuing a fixed list of commands, and then keeps the device refreshed. When a start request arrives in the idle state, it issues a precharge of all banks, then exactly eight auto-refresh commands, then a mode-register load that carries a caller-supplied mode word on the address bus. Each command is followed by a programmable number of NOP cycles that cover the device's recovery time for that command. After the wait that follows the mode-register load, the block raises its ready output and enables periodic refresh.

The refresh period is the product of two run-time values: a prescaler and a refresh-timer count. Refresh requests that arrive while a refresh is still in its recovery window are queued in a backlog counter and served in order, so none are lost. The block only sequences commands. Data transfer, bank mapping and pin timing belong to neighbouring logic.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high and afterwards until a start request, the command pins show deselect ({cs_n,ras_n,cas_n,we_n} = 4'b1111), the address is zero, ready is low and no refresh is issued.
- R2: A start request sampled high in idle puts a precharge-all command (4'b0010) on the pins in the following cycle, with only address bit PRE_ALL_BIT (default 10) set.
- R3: After the precharge comes exactly T_RP NOP cycles (4'b0111), then exactly eight refresh commands (4'b0001), each followed by exactly T_RFC NOP cycles.
- R4: After the NOP gap that follows the eighth refresh, a mode-register load (4'b0000) is issued with the address equal to the mode_word input.
- R5: Ready rises exactly T_MRD+1 cycles after the mode-register load appears, and stays high until reset.
- R6: Periodic refresh is enabled only when ready rises. The first periodic refresh appears exactly P cycles after ready rises, and later ones every P cycles, where P = ref_prescale × ref_count, as long as P exceeds T_RFC.
- R7: A zero value in ref_prescale or ref_count stops new refresh requests.
- R8: A refresh request that arrives during a refresh recovery window is held in a backlog and served later. Back-to-back refreshes are spaced by exactly T_RFC+1 cycles, and the number of refreshes issued equals the number of requests.
- R9: A start request while the sequence runs or in normal operation has no effect on the command stream.
- R10: Reset during normal operation returns the block to idle: deselect on the pins, ready low, and no further refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Starts the power-up sequence when the block is idle |
| ref_prescale | input | PRE_W | Refresh prescaler, in clock cycles per tick |
| ref_count | input | CNT_W | Refresh timer, in ticks per refresh |
| mode_word | input | ADDR_W | Value driven on the address bus with the mode-register load |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Command address (precharge-all bit or mode word) |
| ready_o | output | 1 | High once initialisation is complete |

## Verification
All command outputs are registered. A start request sampled at edge s therefore shows the precharge after edge s, refresh k after edge s+T_RP+1+k(T_RFC+1), and the mode load after edge s+T_RP+1+8(T_RFC+1). Ready follows T_MRD+1 edges after the mode load, and periodic refresh j follows at ready-edge + j·P. The bench counts clock edges and samples every output shortly after the falling edge. It records each non-NOP command with its edge index and compares that index with these formulas. A sweep over small prescaler and timer values checks the period. A run with P below the recovery time checks that the backlog drains to exactly the number of requests.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_NOP   = 4'b0111,
    CMD_PRE   = 4'b0010,
    CMD_REF   = 4'b0001,
    CMD_MRS   = 4'b0000
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_WAIT,
    ST_REF_WAIT,
    ST_MRS_WAIT,
    ST_RUN,
    ST_RUN_WAIT
  } seq_state_e;

endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PRE_W-1:0] prescale,
  input  logic [CNT_W-1:0] count,
  output logic             req
);
  logic [PRE_W-1:0] pc_q;
  logic [CNT_W-1:0] tc_q;
  logic             run, tick, wrap;

  assign run  = en && (prescale != '0) && (count != '0);
  assign tick = run && (pc_q >= prescale - PRE_W'(1));
  assign wrap = tc_q >= count - CNT_W'(1);
  assign req  = tick && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (tick) begin
      pc_q <= '0;
      tc_q <= wrap ? '0 : tc_q + CNT_W'(1);
    end else begin
      pc_q <= pc_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/seq_ref_backlog.sv
module seq_ref_backlog #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         nonzero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else begin
      case ({inc, dec})
        2'b10:   cnt_q <= cnt_q + W'(1);
        2'b01:   cnt_q <= cnt_q - W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt     = cnt_q;
  assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PRE_ALL_BIT = 10,
  parameter int PRE_W       = 8,
  parameter int CNT_W       = 8,
  parameter int PEND_W      = 8,
  parameter int INIT_REFS   = 8,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 7,
  parameter int T_MRD       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [PRE_W-1:0]  ref_prescale,
  input  logic [CNT_W-1:0]  ref_count,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              ready_o
);
  localparam int T_MAX0 = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int T_MAX  = (T_MAX0 > T_MRD) ? T_MAX0 : T_MRD;
  localparam int WAIT_W = (T_MAX < 1) ? 1 : $clog2(T_MAX + 1);
  localparam int RCNT_W = $clog2(INIT_REFS + 1);

  logic [ADDR_W-1:0] pre_all_addr;
  generate
    for (genvar b = 0; b < ADDR_W; b++) begin : g_pre_addr
      assign pre_all_addr[b] = (b == PRE_ALL_BIT);
    end
  endgenerate

  seq_state_e        st_q, st_d;
  sd_cmd_e           cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [RCNT_W-1:0] rcnt_q, rcnt_d;
  logic              ready_q, ready_d;
  logic              ren_q, ren_d;
  logic              wt_load, wt_done;
  logic [WAIT_W-1:0] wt_val;
  logic              ref_req, ref_issue, pend_nz, ref_avail;
  logic [PEND_W-1:0] pend_cnt;

  seq_wait_timer #(.W(WAIT_W)) u_wait (
    .clk(clk), .rst(rst), .load(wt_load), .load_val(wt_val), .done(wt_done)
  );

  seq_refresh_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_rtmr (
    .clk(clk), .rst(rst), .en(ren_q), .prescale(ref_prescale),
    .count(ref_count), .req(ref_req)
  );

  seq_ref_backlog #(.W(PEND_W)) u_blog (
    .clk(clk), .rst(rst), .inc(ref_req), .dec(ref_issue),
    .cnt(pend_cnt), .nonzero(pend_nz)
  );

  assign ref_avail = pend_nz || ref_req;

  always_comb begin
    st_d      = st_q;
    cmd_d     = (st_q == ST_IDLE) ? CMD_DESEL : CMD_NOP;
    addr_d    = '0;
    rcnt_d    = rcnt_q;
    ready_d   = ready_q;
    ren_d     = ren_q;
    wt_load   = 1'b0;
    wt_val    = '0;
    ref_issue = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_req) begin
          cmd_d   = CMD_PRE;
          addr_d  = pre_all_addr;
          wt_load = 1'b1;
          wt_val  = WAIT_W'(T_RP);
          rcnt_d  = '0;
          st_d    = ST_PRE_WAIT;
        end
      end
      ST_PRE_WAIT: begin
        if (wt_done) begin
          cmd_d   = CMD_REF;
          wt_load = 1'b1;
          wt_val  = WAIT_W'(T_RFC);
          rcnt_d  = RCNT_W'(1);
          st_d    = ST_REF_WAIT;
        end
      end
      ST_REF_WAIT: begin
        if (wt_done) begin
          if (rcnt_q == RCNT_W'(INIT_REFS)) begin
            cmd_d   = CMD_MRS;
            addr_d  = mode_word;
            wt_load = 1'b1;
            wt_val  = WAIT_W'(T_MRD);
            st_d    = ST_MRS_WAIT;
          end else begin
            cmd_d   = CMD_REF;
            wt_load = 1'b1;
            wt_val  = WAIT_W'(T_RFC);
            rcnt_d  = rcnt_q + RCNT_W'(1);
          end
        end
      end
      ST_MRS_WAIT: begin
        if (wt_done) begin
          ready_d = 1'b1;
          ren_d   = 1'b1;
          st_d    = ST_RUN;
        end
      end
      ST_RUN: begin
        if (ref_avail) begin
          cmd_d     = CMD_REF;
          wt_load   = 1'b1;
          wt_val    = WAIT_W'(T_RFC);
          ref_issue = 1'b1;
          st_d      = ST_RUN_WAIT;
        end
      end
      ST_RUN_WAIT: begin
        if (wt_done) begin
          if (ref_avail) begin
            cmd_d     = CMD_REF;
            wt_load   = 1'b1;
            wt_val    = WAIT_W'(T_RFC);
            ref_issue = 1'b1;
          end else begin
            st_d = ST_RUN;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cmd_q   <= CMD_DESEL;
      addr_q  <= '0;
      rcnt_q  <= '0;
      ready_q <= 1'b0;
      ren_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      rcnt_q  <= rcnt_d;
      ready_q <= ready_d;
      ren_q   <= ren_d;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr = addr_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int INIT_REFS = 8
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] cmd,
  input logic       ready,
  input logic       pend_full,
  input logic       ref_req,
  input logic       ref_issue
);
  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  logic       is_cmd;
  logic       seen_q, mrs_q;
  logic [4:0] refs_q;

  assign is_cmd = (cmd != C_NOP) && (cmd != C_DES);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      mrs_q  <= 1'b0;
      refs_q <= '0;
    end else begin
      if (is_cmd) seen_q <= 1'b1;
      if (cmd == C_MRS) mrs_q <= 1'b1;
      if (cmd == C_REF && !ready && refs_q != 5'd31) refs_q <= refs_q + 5'd1;
    end
  end

  AST_FIRST_IS_PRE: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && !seen_q) |-> (cmd == C_PRE));                         // R2
  AST_INIT_REF_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_REF && !ready) |-> (refs_q < 5'(INIT_REFS)));          // R3
  AST_MRS_AFTER_REFS: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_MRS) |-> (refs_q == 5'(INIT_REFS)));                   // R4
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);                                                // R5
  AST_READY_NEEDS_MRS: assert property (@(posedge clk) disable iff (rst)
    ready |-> mrs_q);                                                // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (pend_full && ref_req) |-> ref_issue);                           // R8
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.INIT_REFS(INIT_REFS)) u_chk (
  .clk(clk), .rst(rst),
  .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .ready(ready_o), .pend_full(&pend_cnt),
  .ref_req(ref_req), .ref_issue(ref_issue)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
  localparam int AW = 13, PW = 4, CW = 4;
  localparam int TRP = 2, TRFC = 3, TMRD = 2;
  localparam logic [3:0] C_DES = 4'b1111, C_NOP = 4'b0111, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_MRS = 4'b0000;
  localparam int LOGN = 1024;

  logic clk = 1'b0, rst = 1'b1, start_req = 1'b0;
  logic [PW-1:0] presc = '0;
  logic [CW-1:0] rcount = '0;
  logic [AW-1:0] mode = '0;
  logic cs_n, ras_n, cas_n, we_n, ready;
  logic [AW-1:0] addr;

  sdram_init_seq #(.ADDR_W(AW), .PRE_W(PW), .CNT_W(CW), .PEND_W(6),
                   .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD)) u0 (
    .clk(clk), .rst(rst), .start_req(start_req), .ref_prescale(presc),
    .ref_count(rcount), .mode_word(mode), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
    .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_addr(addr), .ready_o(ready)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [3:0]    lc [0:LOGN-1];
  int            lt [0:LOGN-1];
  logic [AW-1:0] la [0:LOGN-1];
  int n_log = 0;
  int rdy_t = -1;
  int checks = 0, errors = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if ({cs_n, ras_n, cas_n, we_n} != C_NOP && {cs_n, ras_n, cas_n, we_n} != C_DES
          && n_log < LOGN) begin
        lc[n_log] = {cs_n, ras_n, cas_n, we_n};
        lt[n_log] = cyc;
        la[n_log] = addr;
        n_log = n_log + 1;
      end
      if (ready && rdy_t < 0) rdy_t = cyc;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    start_req = 1'b0;
    repeat (3) step();
    chk({cs_n, ras_n, cas_n, we_n} == C_DES, "R1 cmd in reset", {cs_n, ras_n, cas_n, we_n}, C_DES);
    chk(ready == 1'b0, "R1 ready in reset", ready, 0);
    rst = 1'b0;
    n_log = 0;
    rdy_t = -1;
  endtask

  // start at the next edge; optional extra start pulses mid-sequence
  task automatic run_init(input logic [AW-1:0] m, input bit poke, output int s);
    mode = m;
    step();
    start_req = 1'b1;
    s = cyc + 1;
    step();
    start_req = 1'b0;
    if (poke) begin
      repeat (4) step();
      start_req = 1'b1;                 // R9: must be ignored
      step();
      start_req = 1'b0;
      repeat (12) step();
      start_req = 1'b1;
      step();
      start_req = 1'b0;
    end
    for (int g = 0; g < 500 && rdy_t < 0; g++) step();
  endtask

  task automatic check_init(input int s, input logic [AW-1:0] m);
    int mt;
    chk(n_log >= 10, "R3 init command count", n_log, 10);
    chk(lc[0] == C_PRE && lt[0] == s, "R2 precharge time", lt[0], s);
    chk(la[0] == AW'(1 << 10), "R2 precharge address", int'(la[0]), 1 << 10);
    for (int k = 0; k < 8; k++) begin
      chk(lc[k+1] == C_REF && lt[k+1] == s + TRP + 1 + k * (TRFC + 1),
          "R3 init refresh time", lt[k+1], s + TRP + 1 + k * (TRFC + 1));
    end
    mt = s + TRP + 1 + 8 * (TRFC + 1);
    chk(lc[9] == C_MRS && lt[9] == mt, "R4 mode load time", lt[9], mt);
    chk(la[9] == m, "R4 mode load address", int'(la[9]), int'(m));
    chk(rdy_t == mt + TMRD + 1, "R5 ready edge", rdy_t, mt + TMRD + 1);
  endtask

  int s, e, c0, p, nreq, bad;

  initial begin
    // R1: reset and idle state
    do_reset();
    chk(addr == '0, "R1 address after reset", int'(addr), 0);
    repeat (10) step();
    chk(n_log == 0, "R1 idle command count", n_log, 0);
    chk(ready == 1'b0, "R1 idle ready", ready, 0);

    // R2..R5, R9 with start pokes during the sequence, timer disabled (R7)
    presc = 4'd0;
    rcount = 4'd3;
    run_init(13'h0232, 1'b1, s);
    check_init(s, 13'h0232);
    repeat (40) step();
    chk(n_log == 10, "R7 zero prescale no refresh", n_log, 10);
    chk(ready == 1'b1, "R5 ready stays high", ready, 1);
    start_req = 1'b1;                                 // R9 during normal operation
    step();
    start_req = 1'b0;
    repeat (20) step();
    chk(n_log == 10, "R9 start ignored in normal mode", n_log, 10);

    // R7: zero refresh count also stops refresh
    do_reset();
    presc = 4'd3;
    rcount = 4'd0;
    run_init(13'h1ABC, 1'b0, s);
    check_init(s, 13'h1ABC);
    repeat (40) step();
    chk(n_log == 10, "R7 zero count no refresh", n_log, 10);

    // R6: sweep of the period over small prescale and count values
    for (int a = 1; a <= 4; a++) begin
      for (int b = 1; b <= 4; b++) begin
        p = a * b;
        if (p > TRFC) begin
          do_reset();
          presc = PW'(a);
          rcount = CW'(b);
          run_init(AW'(a * 16 + b), 1'b0, s);
          e = rdy_t;
          while (cyc < e + 3 * p + 1) step();
          chk(n_log == 13, "R6 periodic refresh count", n_log, 13);
          for (int j = 1; j <= 3; j++) begin
            chk(lc[9+j] == C_REF && lt[9+j] == e + j * p, "R6 periodic refresh time",
                lt[9+j], e + j * p);
          end
        end
      end
    end

    // R8: period shorter than the recovery window; backlog drains fully
    do_reset();
    presc = 4'd2;
    rcount = 4'd1;
    run_init(13'h0055, 1'b0, s);
    e = rdy_t;
    while (cyc < e + 60) step();
    c0 = cyc;
    presc = 4'd0;
    nreq = (c0 - e) / 2;
    repeat (200) step();
    chk(n_log - 10 == nreq, "R8 refreshes equal requests", n_log - 10, nreq);
    chk(lt[10] == e + 2, "R8 first periodic refresh", lt[10], e + 2);
    bad = 0;
    for (int i = 11; i < n_log; i++) begin
      if (lc[i] != C_REF || lt[i] - lt[i-1] != TRFC + 1) bad++;
    end
    chk(bad == 0, "R8 backlog spacing errors", bad, 0);

    // R10: reset during normal operation
    presc = 4'd2;
    repeat (10) step();
    rst = 1'b1;
    repeat (2) step();
    chk({cs_n, ras_n, cas_n, we_n} == C_DES, "R10 cmd after reset", {cs_n, ras_n, cas_n, we_n}, C_DES);
    chk(ready == 1'b0, "R10 ready after reset", ready, 0);
    rst = 1'b0;
    n_log = 0;
    repeat (30) step();
    chk(n_log == 0, "R10 no refresh after reset", n_log, 0);
    chk(ready == 1'b0, "R10 ready stays low", ready, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule